// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves data from a memory read port to a peripheral. Each job is described by a chain of descriptors held in a small descriptor store inside the channel. A descriptor gives a source address, a destination address, an increment-or-hold flag for each side, a beat width code, a burst length, a byte count, a next index and a last-in-chain flag. Software fills the store through a write port. It then issues a start command that carries the index of the head descriptor. The channel walks the chain one descriptor at a time. When the peripheral raises its request line, the channel moves one burst and marks the final beat of that burst with an acknowledge pulse.

A transfer can be marked to repeat. A repeating transfer restarts from its head each time its chain ends. A command issued while the channel is busy waits in a one-entry slot. For a repeating transfer, that command takes over at the end of the chain only if it carries the load-at-end flag; otherwise it is thrown away. For a transfer that does not repeat, the waiting command always starts at the end of the chain. A chain whose last descriptor points back to an earlier one never ends, which gives cyclic operation. A pause input freezes beats at once. A terminate pulse drops the active and pending work and raises no interrupt for it. The residue output reports the bytes left in the current descriptor, and a granularity select sets how often it is refreshed.

Top module: `chain_dma`

## Requirements
- R1: After reset the channel is idle: busy, irq, err and residue are 0 and no memory read is requested. A start command issued while idle walks the chain from the head index, following the next index until it reaches a descriptor whose last flag is set, and then returns to idle. cur_idx shows the descriptor being worked on.
- R2: Width code 0, 1, 2 or 3 moves 1, 2, 3 or 4 bytes per beat. The final beat of a descriptor carries min(remaining bytes, width). per_bytes gives the byte count of each beat.
- R3: The beat data written to the peripheral is the memory word read at the source address. The source address advances by the beat width after each beat when its increment flag is 1 and stays fixed when the flag is 0. The destination address per_addr follows the same rule with its own flag.
- R4: Each service of per_req moves at most (burst field + 1) beats and never crosses a descriptor end. per_ack pulses together with the peripheral write of the last beat of each burst and at no other time.
- R5: irq is a one-cycle pulse at the completion of every descriptor.
- R6: A chain whose last descriptor has its last flag at 0 and points back to an earlier descriptor runs again and again until it is terminated.
- R7: In a repeating transfer, the chain restarts from its head when it ends. A queued command with the load-at-end flag replaces it at that chain end. A queued command without that flag is discarded at that chain end, and the repeat goes on.
- R8: In a transfer that does not repeat, a queued command starts at the chain end whether or not its load-at-end flag is set. With no queued command the channel goes idle.
- R9: While pause is 1, no memory read is requested and no beat is written, starting from the next clock edge. paused reads 1 while the channel is busy and paused. Clearing pause lets the transfer go on where it stopped.
- R10: cmd_term returns the channel to idle on the next edge. It drops any queued command and raises no irq for the dropped work.
- R11: residue is loaded with the byte count when a descriptor starts and is cleared when the descriptor completes. Between those points it is refreshed on every beat when res_gran=2, at each burst end when res_gran=1, and not at all when res_gran is 0 or 3.
- R12: A descriptor with a width code of 4 to 7 sets err. The channel halts with no irq and drops the queued command. err clears when the next start command is accepted.
- R13: A command issued in the same cycle in which the chain ends is treated as queued, and it is taken over at that chain end under the rules of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one descriptor entry |
| cfg_idx | input | IW | Entry index to write |
| cfg_src | input | AW | Source address |
| cfg_dst | input | AW | Destination address |
| cfg_sinc | input | 1 | 1: source advances per beat |
| cfg_dinc | input | 1 | 1: destination advances per beat |
| cfg_wcode | input | 3 | Width code (0..3 valid) |
| cfg_blen | input | BLW | Beats per burst minus one |
| cfg_cnt | input | CW | Byte count |
| cfg_next | input | IW | Next entry index |
| cfg_last | input | 1 | Entry ends the chain |
| cmd_go | input | 1 | Start or queue a transfer |
| cmd_head | input | IW | Head entry of the transfer |
| cmd_rep | input | 1 | Transfer repeats |
| cmd_eot | input | 1 | Replace a repeating transfer at its end |
| cmd_term | input | 1 | Terminate all work |
| pause | input | 1 | Hold beats while 1 |
| res_gran | input | 2 | Residue refresh granularity |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_ready | input | 1 | Memory read completes, data valid |
| mem_rd_data | input | DW | Memory read data |
| per_req | input | 1 | Peripheral requests a burst |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | AW | Peripheral write address |
| per_data | output | DW | Peripheral write data |
| per_bytes | output | 3 | Bytes valid in this beat |
| per_ack | output | 1 | Last beat of a burst |
| irq | output | 1 | Descriptor-complete pulse |
| busy | output | 1 | Channel active |
| paused | output | 1 | Busy and held by pause |
| cur_idx | output | IW | Current descriptor index |
| err | output | 1 | Invalid width code seen |
| residue | output | CW | Bytes left in the current descriptor |

## Verification
The end of a chain and the arrival of a new command can land in the same clock cycle. At that point the channel must decide between restarting, switching and going idle, while a command is also being written into the pending slot. The bench provokes this by running with full memory and request throughput. It watches for the single write beat of the final descriptor and drives the command in that same cycle, once with a transfer that does not repeat and once with a repeating transfer and a load-at-end command. It then judges the result from the beat stream: the new descriptor's beats must follow without the channel going idle, the old transfer must not run again, and exactly two interrupts must be raised.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int ND = 8,
  parameter int CW = 12,
  parameter int BLW = 4,
  localparam int IW = $clog2(ND)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic          cfg_sinc,
  input  logic          cfg_dinc,
  input  logic [2:0]    cfg_wcode,
  input  logic [BLW-1:0] cfg_blen,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [IW-1:0] cfg_next,
  input  logic          cfg_last,
  input  logic          cmd_go,
  input  logic [IW-1:0] cmd_head,
  input  logic          cmd_rep,
  input  logic          cmd_eot,
  input  logic          cmd_term,
  input  logic          pause,
  input  logic [1:0]    res_gran,
  output logic          mem_rd_valid,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ready,
  input  logic [DW-1:0] mem_rd_data,
  input  logic          per_req,
  output logic          per_wr,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_data,
  output logic [2:0]    per_bytes,
  output logic          per_ack,
  output logic          irq,
  output logic          busy,
  output logic          paused,
  output logic [IW-1:0] cur_idx,
  output logic          err,
  output logic [CW-1:0] residue
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_BURST, S_DONE} st_t;

  logic [AW-1:0]  m_src [ND];
  logic [AW-1:0]  m_dst [ND];
  logic           m_si  [ND];
  logic           m_di  [ND];
  logic [2:0]     m_w   [ND];
  logic [BLW-1:0] m_bl  [ND];
  logic [CW-1:0]  m_cnt [ND];
  logic [IW-1:0]  m_nx  [ND];
  logic           m_ls  [ND];

  always_ff @(posedge clk)
    if (cfg_we) begin
      m_src[cfg_idx] <= cfg_src;
      m_dst[cfg_idx] <= cfg_dst;
      m_si[cfg_idx]  <= cfg_sinc;
      m_di[cfg_idx]  <= cfg_dinc;
      m_w[cfg_idx]   <= cfg_wcode;
      m_bl[cfg_idx]  <= cfg_blen;
      m_cnt[cfg_idx] <= cfg_cnt;
      m_nx[cfg_idx]  <= cfg_next;
      m_ls[cfg_idx]  <= cfg_last;
    end

  st_t            st;
  logic [IW-1:0]  cur, head, nx;
  logic           rep, ls, si, di;
  logic [AW-1:0]  sa, da;
  logic [2:0]     wb;
  logic [BLW-1:0] bl;
  logic [BLW:0]   bc;
  logic [CW-1:0]  rem, res_q;
  logic           err_q;
  logic           q_v, q_r, q_e;
  logic [IW-1:0]  q_h;

  logic [2:0]    wc_cur;
  logic [CW-1:0] wbx, step, rem_n;
  logic [AW-1:0] wba;
  logic          beat, last_beat, burst_end;
  logic          p_v, p_r, p_e, swap;
  logic [IW-1:0] p_h;

  assign wc_cur    = m_w[cur];
  assign wbx       = {{(CW-3){1'b0}}, wb};
  assign wba       = {{(AW-3){1'b0}}, wb};
  assign step      = (rem < wbx) ? rem : wbx;
  assign rem_n     = rem - step;
  assign last_beat = (rem_n == '0);
  assign burst_end = last_beat || (bc == {{BLW{1'b0}}, 1'b1});

  assign mem_rd_valid = (st == S_BURST) && !pause;
  assign mem_rd_addr  = sa;
  assign beat         = mem_rd_valid && mem_rd_ready;

  assign p_v  = q_v | cmd_go;
  assign p_h  = cmd_go ? cmd_head : q_h;
  assign p_r  = cmd_go ? cmd_rep  : q_r;
  assign p_e  = cmd_go ? cmd_eot  : q_e;
  assign swap = rep ? (p_v && p_e) : p_v;

  assign busy    = (st != S_IDLE);
  assign paused  = busy && pause;
  assign cur_idx = cur;
  assign err     = err_q;
  assign residue = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0; head <= '0; nx <= '0;
      rep <= 1'b0; ls <= 1'b0; si <= 1'b0; di <= 1'b0;
      sa <= '0; da <= '0; wb <= 3'd1; bl <= '0; bc <= '0;
      rem <= '0; res_q <= '0; err_q <= 1'b0;
      q_v <= 1'b0; q_r <= 1'b0; q_e <= 1'b0; q_h <= '0;
      per_wr <= 1'b0; per_ack <= 1'b0; irq <= 1'b0;
      per_addr <= '0; per_data <= '0; per_bytes <= '0;
    end else begin
      per_wr  <= 1'b0;
      per_ack <= 1'b0;
      irq     <= 1'b0;
      if (cmd_term) begin
        st  <= S_IDLE;
        q_v <= 1'b0;
        rep <= 1'b0;
      end else begin
        if (cmd_go && st != S_IDLE) begin
          q_v <= 1'b1;
          q_h <= cmd_head;
          q_r <= cmd_rep;
          q_e <= cmd_eot;
        end
        case (st)
          S_IDLE:
            if (cmd_go) begin
              cur   <= cmd_head;
              head  <= cmd_head;
              rep   <= cmd_rep;
              err_q <= 1'b0;
              st    <= S_LOAD;
            end
          S_LOAD: begin
            sa    <= m_src[cur];
            da    <= m_dst[cur];
            si    <= m_si[cur];
            di    <= m_di[cur];
            wb    <= {1'b0, wc_cur[1:0]} + 3'd1;
            bl    <= m_bl[cur];
            nx    <= m_nx[cur];
            ls    <= m_ls[cur];
            rem   <= m_cnt[cur];
            res_q <= m_cnt[cur];
            if (wc_cur[2]) begin
              err_q <= 1'b1;
              q_v   <= 1'b0;
              rep   <= 1'b0;
              st    <= S_IDLE;
            end else if (m_cnt[cur] == '0) st <= S_DONE;
            else st <= S_WAIT;
          end
          S_WAIT:
            if (per_req && !pause) begin
              bc <= {1'b0, bl} + {{BLW{1'b0}}, 1'b1};
              st <= S_BURST;
            end
          S_BURST:
            if (beat) begin
              per_wr    <= 1'b1;
              per_data  <= mem_rd_data;
              per_addr  <= da;
              per_bytes <= step[2:0];
              if (si) sa <= sa + wba;
              if (di) da <= da + wba;
              rem <= rem_n;
              bc  <= bc - {{BLW{1'b0}}, 1'b1};
              if (res_gran == 2'd2) res_q <= rem_n;
              if (burst_end) begin
                per_ack <= 1'b1;
                if (res_gran == 2'd1) res_q <= rem_n;
                st <= last_beat ? S_DONE : S_WAIT;
              end
            end
          S_DONE: begin
            irq   <= 1'b1;
            res_q <= '0;
            st    <= S_LOAD;
            if (!ls) cur <= nx;
            else begin
              q_v <= 1'b0;
              if (swap) begin
                cur  <= p_h;
                head <= p_h;
                rep  <= p_r;
              end else if (rep) cur <= head;
              else st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pause,
  input logic       cmd_term,
  input logic       mem_rd_valid,
  input logic       per_wr,
  input logic       per_ack,
  input logic [2:0] per_bytes,
  input logic       irq,
  input logic       busy,
  input logic       err
);

  p_idle_no_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_valid);

  p_beat_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |-> (per_bytes >= 3'd1 && per_bytes <= 3'd4));

  p_ack_on_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> per_wr);

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_pause_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pause |=> !per_wr);

  p_term_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_term |=> (!busy && !irq && !per_wr));

  p_err_halted_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

endmodule

bind chain_dma chain_dma_chk u_chk (.*);

// File: tb/chain_dma_test.sv
module chain_dma_test;
  localparam int AW = 16, DW = 32, ND = 8, CW = 12, BLW = 4, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_sinc = 0, cfg_dinc = 0, cfg_last = 0;
  logic [IW-1:0] cfg_idx = '0, cfg_next = '0, cmd_head = '0, cur_idx;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0, mem_rd_addr, per_addr;
  logic [2:0] cfg_wcode = '0, per_bytes;
  logic [BLW-1:0] cfg_blen = '0;
  logic [CW-1:0] cfg_cnt = '0, residue;
  logic cmd_go = 0, cmd_rep = 0, cmd_eot = 0, cmd_term = 0, pause = 0;
  logic [1:0] gran = 2'd0;
  logic mem_rd_valid, mem_rd_ready, per_req, per_wr, per_ack, irq, busy, paused, err;
  logic [DW-1:0] mem_rd_data, per_data;
  logic fast = 0, req_en = 0, rnd_rdy = 0, rnd_req = 0;

  function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
    return {a ^ 16'hc3a5, a};
  endfunction

  assign mem_rd_data  = mdata(mem_rd_addr);
  assign mem_rd_ready = fast | rnd_rdy;
  assign per_req      = req_en & (fast | rnd_req);

  chain_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_sinc(cfg_sinc), .cfg_dinc(cfg_dinc), .cfg_wcode(cfg_wcode),
    .cfg_blen(cfg_blen), .cfg_cnt(cfg_cnt), .cfg_next(cfg_next), .cfg_last(cfg_last),
    .cmd_go(cmd_go), .cmd_head(cmd_head), .cmd_rep(cmd_rep), .cmd_eot(cmd_eot),
    .cmd_term(cmd_term), .pause(pause), .res_gran(gran), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
    .per_req(per_req), .per_wr(per_wr), .per_addr(per_addr), .per_data(per_data),
    .per_bytes(per_bytes), .per_ack(per_ack), .irq(irq), .busy(busy), .paused(paused),
    .cur_idx(cur_idx), .err(err), .residue(residue));

  typedef struct packed {
    logic [AW-1:0] a; logic [DW-1:0] d; logic [2:0] b; logic ack;
    logic [CW-1:0] ra; logic [CW-1:0] cnt;
  } exp_t;
  exp_t eq[$];

  logic [AW-1:0] sh_src[ND], sh_dst[ND];
  logic sh_si[ND], sh_di[ND];
  logic [2:0] sh_w[ND];
  logic [BLW-1:0] sh_bl[ND];
  logic [CW-1:0] sh_cnt[ND];

  int checks = 0, errs = 0, nirq = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rnd_rdy <= ($urandom % 4) != 0;
    rnd_req <= ($urandom % 3) != 0;
    if (rst_n && irq) nirq <= nirq + 1;
    if (rst_n && per_wr) begin
      if (eq.size() == 0) chk(0, "R1 unexpected beat", per_addr, -1);
      else begin
        exp_t e;
        e = eq.pop_front();
        chk(per_addr == e.a, "R3 dst addr", per_addr, e.a);
        chk(per_data == e.d, "R3 src data", per_data, e.d);
        chk(per_bytes == e.b, "R2 beat bytes", per_bytes, e.b);
        chk(per_ack == e.ack, "R4 burst ack", per_ack, e.ack);
        if (gran == 2'd2) chk(residue == e.ra, "R11 beat residue", residue, e.ra);
        else if (gran == 2'd1 && e.ack) chk(residue == e.ra, "R11 burst residue", residue, e.ra);
        else if (gran == 2'd0) chk(residue == e.cnt, "R11 segment residue", residue, e.cnt);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wdesc(input int i, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input bit sinc, input bit dinc, input logic [2:0] wc,
                       input logic [BLW-1:0] b, input logic [CW-1:0] c,
                       input int nxt, input bit last);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(i); cfg_src = s; cfg_dst = d; cfg_sinc = sinc;
    cfg_dinc = dinc; cfg_wcode = wc; cfg_blen = b; cfg_cnt = c;
    cfg_next = IW'(nxt); cfg_last = last;
    sh_src[i] = s; sh_dst[i] = d; sh_si[i] = sinc; sh_di[i] = dinc;
    sh_w[i] = wc; sh_bl[i] = b; sh_cnt[i] = c;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push_desc(input int i);
    logic [CW-1:0] rem, stp;
    logic [AW-1:0] s, d;
    int w, k;
    exp_t e;
    rem = sh_cnt[i]; s = sh_src[i]; d = sh_dst[i];
    w = int'(sh_w[i]) + 1; k = 0;
    while (rem != 0) begin
      stp = (rem < CW'(w)) ? rem : CW'(w);
      e.a = d; e.d = mdata(s); e.b = stp[2:0];
      e.ra = rem - stp; e.cnt = sh_cnt[i];
      e.ack = (k == int'(sh_bl[i])) || (e.ra == 0);
      eq.push_back(e);
      k = e.ack ? 0 : k + 1;
      rem = rem - stp;
      if (sh_si[i]) s = s + AW'(w);
      if (sh_di[i]) d = d + AW'(w);
    end
  endtask

  task automatic go(input int h, input bit r, input bit eot);
    @(negedge clk);
    cmd_go = 1; cmd_head = IW'(h); cmd_rep = r; cmd_eot = eot;
    @(negedge clk);
    cmd_go = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, "R1 idle timeout", t, 0);
    tick(2);
  endtask

  task automatic wait_irq(input int target);
    int t = 0;
    while (nirq < target && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk(0, "R5 irq timeout", nirq, target);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int i0;
    void'($urandom(32'd11));
    tick(3);
    rst_n = 1;
    tick(1);
    chk(!busy && !irq && !err, "R1 reset idle", {busy, irq, err}, 0);
    chk(residue == 0, "R1 reset residue", residue, 0);
    chk(!mem_rd_valid, "R1 reset no read", mem_rd_valid, 0);

    // R1 R5 directed two-entry chain
    gran = 2'd1; req_en = 1;
    wdesc(0, 16'h0100, 16'h8000, 1, 0, 3'd3, 4'd1, 12'd10, 1, 0);
    wdesc(1, 16'h0200, 16'h8004, 1, 1, 3'd1, 4'd2, 12'd7, 0, 1);
    push_desc(0); push_desc(1);
    i0 = nirq;
    go(0, 0, 0);
    wait_idle();
    chk(nirq - i0 == 2, "R5 irq per descriptor", nirq - i0, 2);
    chk(eq.size() == 0, "R1 chain walked", eq.size(), 0);
    chk(cur_idx == 1, "R1 cur_idx last", cur_idx, 1);

    // R2 R3 R4 R11 constrained random chains
    for (int k = 0; k < 12; k++) begin
      int n;
      gran = 2'(k % 3);
      n = 1 + ($urandom % 3);
      for (int j = 0; j < n; j++)
        wdesc(2 + j, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
              3'($urandom % 4), 4'($urandom % 4), 12'(1 + $urandom % 24), 3 + j, j == n - 1);
      for (int j = 0; j < n; j++) push_desc(2 + j);
      i0 = nirq;
      go(2, 0, 0);
      wait_idle();
      chk(nirq - i0 == n, "R5 random irq count", nirq - i0, n);
      chk(eq.size() == 0, "R4 random beats done", eq.size(), 0);
    end

    // R9 pause
    gran = 2'd2;
    wdesc(4, 16'h0400, 16'h9000, 1, 1, 3'd0, 4'd7, 12'd40, 0, 1);
    push_desc(4);
    go(4, 0, 0);
    tick(8);
    pause = 1;
    tick(1);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk(!per_wr && !mem_rd_valid, "R9 held", {per_wr, mem_rd_valid}, 0);
      chk(paused, "R9 paused status", paused, 1);
    end
    pause = 0;
    wait_idle();
    chk(eq.size() == 0, "R9 resumed to end", eq.size(), 0);

    // R6 R10 cyclic then terminate
    gran = 2'd0;
    wdesc(5, 16'h0500, 16'ha000, 1, 0, 3'd1, 4'd0, 12'd6, 6, 0);
    wdesc(6, 16'h0600, 16'ha000, 1, 0, 3'd3, 4'd0, 12'd4, 5, 0);
    for (int j = 0; j < 4; j++) begin push_desc(5); push_desc(6); end
    i0 = nirq;
    go(5, 0, 0);
    wait_irq(i0 + 5);
    chk(busy, "R6 cyclic still running", busy, 1);
    @(negedge clk); cmd_term = 1;
    @(negedge clk); cmd_term = 0;
    chk(!busy, "R10 terminated idle", busy, 0);
    i0 = nirq;
    tick(20);
    chk(nirq == i0, "R10 no irq after terminate", nirq, i0);
    eq.delete();

    // R7 repeat: plain queued ignored, load-at-end replaces
    gran = 2'd1; req_en = 0;
    wdesc(0, 16'h0700, 16'hb000, 1, 1, 3'd3, 4'd1, 12'd8, 0, 1);
    wdesc(1, 16'h0780, 16'hb100, 1, 1, 3'd0, 4'd0, 12'd3, 0, 1);
    wdesc(2, 16'h07c0, 16'hb200, 1, 0, 3'd2, 4'd3, 12'd5, 0, 1);
    push_desc(0); push_desc(0); push_desc(0);
    i0 = nirq;
    go(0, 1, 0);
    tick(3);
    go(1, 0, 0);
    req_en = 1;
    wait_irq(i0 + 2);
    req_en = 0;
    tick(3);
    go(2, 0, 1);
    push_desc(2);
    req_en = 1;
    wait_idle();
    chk(eq.size() == 0, "R7 repeat then replaced", eq.size(), 0);
    chk(nirq - i0 == 4, "R7 irq count", nirq - i0, 4);

    // R8 non-repeat: queued without load-at-end still runs
    req_en = 0;
    wdesc(3, 16'h0800, 16'hc000, 1, 1, 3'd1, 4'd0, 12'd6, 0, 1);
    wdesc(4, 16'h0900, 16'hc100, 0, 1, 3'd3, 4'd0, 12'd4, 0, 1);
    push_desc(3); push_desc(4);
    i0 = nirq;
    go(3, 0, 0);
    tick(3);
    go(4, 0, 0);
    req_en = 1;
    wait_idle();
    chk(eq.size() == 0, "R8 queued follows", eq.size(), 0);
    chk(nirq - i0 == 2, "R8 irq count", nirq - i0, 2);

    // R13 command in the chain-end cycle
    fast = 1;
    wdesc(5, 16'h0a00, 16'hd000, 1, 1, 3'd3, 4'd0, 12'd4, 0, 1);
    wdesc(6, 16'h0b00, 16'hd100, 1, 1, 3'd1, 4'd0, 12'd2, 0, 1);
    for (int v = 0; v < 2; v++) begin
      push_desc(5); push_desc(6);
      i0 = nirq;
      go(5, v == 1, 0);
      while (!per_wr) @(negedge clk);
      cmd_go = 1; cmd_head = 3'd6; cmd_rep = 0; cmd_eot = (v == 1);
      @(negedge clk);
      cmd_go = 0;
      chk(busy, "R13 no idle gap", busy, 1);
      wait_idle();
      chk(eq.size() == 0, "R13 taken at boundary", eq.size(), 0);
      chk(nirq - i0 == 2, "R13 irq count", nirq - i0, 2);
    end
    fast = 0;

    // R12 invalid width
    wdesc(7, 16'h0c00, 16'he000, 1, 1, 3'd5, 4'd0, 12'd4, 0, 1);
    i0 = nirq;
    go(7, 0, 0);
    tick(4);
    chk(err, "R12 err set", err, 1);
    chk(!busy, "R12 halted", busy, 0);
    chk(nirq == i0, "R12 no irq", nirq, i0);
    wdesc(7, 16'h0c00, 16'he000, 1, 1, 3'd0, 4'd0, 12'd2, 0, 1);
    push_desc(7);
    go(7, 0, 0);
    chk(!err, "R12 err cleared", err, 0);
    wait_idle();
    chk(eq.size() == 0, "R12 recovers", eq.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule